// File: doc/BRIEF.md
# Slope-Compensation DAC Trigger Generator

This block watches a PWM timer's counter and its output-1 set and reset events, and produces two single-clock strobes for an external sawtooth DAC. The reset strobe restarts the sawtooth and the step strobe moves it one step. Together they provide peak-current-mode slope compensation, or the two thresholds of a hysteretic controller.

Two select inputs choose the source of each strobe. The reset strobe can come from the counter roll-over or from the output-1 set event. The step strobe can come from the output-1 reset event or from a self-advancing compare threshold. In that compare mode, every reset strobe reloads the threshold to a base plus the compare-2 value. The base is 0 for roll-over reset and the current count for set-event reset. Each match then pushes the threshold forward by the compare-2 value, so a single compare value yields evenly spaced steps through the period. Roll-over reset with compare stepping gives edge-aligned compensation. Set-event reset with compare stepping gives center-aligned compensation.

Top module: `slope_trig_gen`

## Requirements
- R1: With `enable` high and `rstFromSet` low, a cycle with `rollOver` high gives a `dacRstTrg` pulse one clock later.
- R2: With `enable` high and `rstFromSet` high, a cycle with `out1Set` high gives a `dacRstTrg` pulse one clock later, and `rollOver` makes no reset strobe.
- R3: With `enable` high and `stepFromReset` high, a cycle with `out1Rst` high gives a `dacStepTrg` pulse one clock later, unless a reset strobe is produced in that same cycle.
- R4: With `stepFromReset` low, a reset event arms a threshold at base plus `cmp2Val`. Each cycle with `cnt` equal to the threshold gives a step pulse one clock later and advances the threshold by `cmp2Val`. Steps are therefore spaced `cmp2Val` counts apart.
- R5: A threshold that would exceed `period` disarms compare stepping until the next reset event. With period 20 and step 7, each armed period yields exactly two steps.
- R6: A compare match in a cycle where `rollOver` is high is dropped. With period 20 and step 10, each armed period yields one step.
- R7: For roll-over reset the threshold base is 0. For set-event reset the base is the count at the set event, and a roll-over disarms compare stepping.
- R8: When a reset strobe and a step strobe fall in the same cycle, only the reset strobe is produced; `dacRstTrg` and `dacStepTrg` are never high together.
- R9: A `cmp2Val` of zero at a reset event leaves compare stepping disarmed, so no compare steps occur.
- R10: With `enable` low, both strobes stay low and compare stepping is disarmed.
- R11: While `rst_n` is low, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Trigger generation on (both sources configured) |
| rstFromSet | input | 1 | Reset source: 0 roll-over, 1 output-1 set event |
| stepFromReset | input | 1 | Step source: 0 repeated compare, 1 output-1 reset event |
| cnt | input | CNT_W | PWM counter value |
| period | input | CNT_W | PWM period (counter runs 0..period) |
| cmp2Val | input | CNT_W | Step interval for compare stepping |
| rollOver | input | 1 | Counter roll-over pulse (high in the cycle cnt equals period) |
| out1Set | input | 1 | Output-1 set event pulse |
| out1Rst | input | 1 | Output-1 reset event pulse |
| dacRstTrg | output | 1 | DAC reset strobe |
| dacStepTrg | output | 1 | DAC step strobe |

## Verification
Some properties are checked by assertions on every cycle. These are the mutual exclusion of the two strobes, silence while disabled, a roll-over blocking a compare step, the one-clock follow of roll-over and out1-reset events, and a zero step value leaving the compare disarmed. The spacing of compare steps, the disarm past the period and the center-aligned threshold base depend on a whole counter sweep. Only the bench scenarios show those, through the per-cycle reference model and the step counts per scenario.

// File: rtl/slope_trig_pkg.sv
package slope_trig_pkg;
  typedef struct packed {
    logic load;        // reload threshold from base + step
    logic baseFromCnt; // base is the current count (else zero)
    logic advance;     // move threshold forward by one step
    logic disarm;      // stop compare stepping
  } accCmd_t;
endpackage

// File: rtl/slope_trig_acc.sv
module slope_trig_acc
  import slope_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  accCmd_t          cmd,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp2Val,
  output logic             cmpHit
);
  localparam int ACC_W = CNT_W + 1;

  logic [ACC_W-1:0] thr, nextThr, base, stepExt, perExt;
  logic armed, nextArmed;

  assign stepExt = {1'b0, cmp2Val};
  assign perExt  = {1'b0, period};
  assign base    = cmd.baseFromCnt ? {1'b0, cnt} : '0;

  always_comb begin
    nextThr   = thr;
    nextArmed = armed;
    if (cmd.load) begin
      nextThr   = base + stepExt;
      nextArmed = (cmp2Val != '0) && (nextThr <= perExt);
    end else if (cmd.advance) begin
      nextThr   = thr + stepExt;
      nextArmed = (nextThr <= perExt);
    end else if (cmd.disarm) begin
      nextArmed = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr   <= '0;
      armed <= 1'b0;
    end else begin
      thr   <= nextThr;
      armed <= nextArmed;
    end
  end

  assign cmpHit = armed && (thr == {1'b0, cnt});

  // R9: a zero step at reload can never produce a match afterwards
  a_r9_zero_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.load && cmp2Val == '0) |=> !cmpHit);

  // R10: a disarm command without reload silences the compare
  a_r10_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.disarm && !cmd.load && !cmd.advance) |=> !cmpHit);
endmodule

// File: rtl/slope_trig_ctrl.sv
module slope_trig_ctrl
  import slope_trig_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    rstFromSet,
  input  logic    stepFromReset,
  input  logic    rollOver,
  input  logic    out1Set,
  input  logic    out1Rst,
  input  logic    cmpHit,
  output accCmd_t cmd,
  output logic    rstTrg,
  output logic    stepTrg
);
  logic rstEvt, cmpStep, stepEvt;

  assign rstEvt  = enable && (rstFromSet ? out1Set : rollOver);
  assign cmpStep = enable && !stepFromReset && cmpHit && !rollOver && !rstEvt;
  assign stepEvt = enable && !rstEvt && (stepFromReset ? out1Rst : cmpStep);

  always_comb begin
    cmd.load        = rstEvt;
    cmd.baseFromCnt = rstFromSet;
    cmd.advance     = cmpStep;
    cmd.disarm      = !enable || (rstFromSet && rollOver);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstTrg  <= 1'b0;
      stepTrg <= 1'b0;
    end else begin
      rstTrg  <= rstEvt;
      stepTrg <= stepEvt;
    end
  end

  // R8: the two strobes never coincide
  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !(rstTrg && stepTrg));

  // R10: nothing comes out while disabled
  a_r10_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rstTrg && !stepTrg));

  // R6: a roll-over blocks any compare step in its cycle
  a_r6_rollover_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stepFromReset && rollOver) |=> !stepTrg);

  // R1: roll-over reset follows one clock later
  a_r1_rollover_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !rstFromSet && rollOver) |=> rstTrg);

  // R3: out1 reset step follows when no reset competes
  a_r3_follow_out1_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stepFromReset && out1Rst && !rstFromSet && !rollOver) |=> stepTrg);
endmodule

// File: rtl/slope_trig_gen.sv
module slope_trig_gen
  import slope_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rstFromSet,
  input  logic             stepFromReset,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp2Val,
  input  logic             rollOver,
  input  logic             out1Set,
  input  logic             out1Rst,
  output logic             dacRstTrg,
  output logic             dacStepTrg
);
  accCmd_t cmd;
  logic    cmpHit;

  slope_trig_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rstFromSet(rstFromSet),
    .stepFromReset(stepFromReset), .rollOver(rollOver), .out1Set(out1Set),
    .out1Rst(out1Rst), .cmpHit(cmpHit), .cmd(cmd),
    .rstTrg(dacRstTrg), .stepTrg(dacStepTrg)
  );

  slope_trig_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cnt(cnt), .period(period),
    .cmp2Val(cmp2Val), .cmpHit(cmpHit)
  );
endmodule

// File: tb/slope_trig_gen_test.sv
module slope_trig_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, rstFromSet = 1'b0, stepFromReset = 1'b0;
  logic [15:0] cnt = '0, period = 16'd20, cmp2Val = '0;
  logic rollOver = 1'b0, out1Set = 1'b0, out1Rst = 1'b0;
  logic dacRstTrg, dacStepTrg;

  int checks = 0, errors = 0;
  int stepSeen = 0, rstSeen = 0;
  string tag = "R11";

  // reference model state
  int  mThr = 0;
  bit  mArmed = 0;
  bit  expR = 0, expS = 0;

  always #5 clk = ~clk;

  slope_trig_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rstFromSet(rstFromSet),
    .stepFromReset(stepFromReset), .cnt(cnt), .period(period), .cmp2Val(cmp2Val),
    .rollOver(rollOver), .out1Set(out1Set), .out1Rst(out1Rst),
    .dacRstTrg(dacRstTrg), .dacStepTrg(dacStepTrg)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mArmed = 0; mThr = 0; expR <= 0; expS <= 0;
    end else begin
      bit r, hit, s;
      r   = enable && (rstFromSet ? out1Set : rollOver);
      hit = mArmed && (int'(cnt) == mThr);
      s   = enable && !r && (stepFromReset ? out1Rst : (hit && !rollOver));
      expR <= r;
      expS <= s;
      if (!enable) mArmed = 0;
      else if (r) begin
        mThr   = (rstFromSet ? int'(cnt) : 0) + int'(cmp2Val);
        mArmed = (cmp2Val != 0) && (mThr <= int'(period));
      end else if (hit && !rollOver && !stepFromReset) begin
        mThr   = mThr + int'(cmp2Val);
        mArmed = (mThr <= int'(period));
      end else if (rollOver && rstFromSet) mArmed = 0;
    end
  end

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycleCheck();
    if (rst_n) begin
      checkEq(tag, "dacRstTrg", int'(dacRstTrg), int'(expR));
      checkEq(tag, "dacStepTrg", int'(dacStepTrg), int'(expS));
      stepSeen += int'(dacStepTrg);
      rstSeen  += int'(dacRstTrg);
    end
  endtask

  task automatic runPeriods(int n, int setPt, int rstPt);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c <= int'(period); c++) begin
        @(negedge clk);
        cycleCheck();
        cnt      = c[15:0];
        rollOver = (c == int'(period));
        out1Set  = (c == setPt);
        out1Rst  = (c == rstPt);
      end
    end
    @(negedge clk);
    cycleCheck();
    cnt = '0; rollOver = 0; out1Set = 0; out1Rst = 0;
    @(negedge clk);
    cycleCheck();
  endtask

  task automatic scen(string t, bit e, bit rs, bit ss, int cmp, int setPt,
                      int rstPt, int expSteps, int expRsts);
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tag = t;
    enable = e; rstFromSet = rs; stepFromReset = ss; cmp2Val = cmp[15:0];
    stepSeen = 0; rstSeen = 0;
    runPeriods(3, setPt, rstPt);
    checkEq(t, "step count", stepSeen, expSteps);
    checkEq(t, "reset count", rstSeen, expRsts);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    checkEq("R11", "dacRstTrg in reset", int'(dacRstTrg), 0);
    checkEq("R11", "dacStepTrg in reset", int'(dacStepTrg), 0);
    rst_n = 1;
    // R1 R4: roll-over reset, compare steps every 5 counts (20 dropped)
    scen("R4", 1, 0, 0, 5, -1, -1, 6, 3);
    // R5: step 7 gives 7 and 14, then 21 exceeds the period
    scen("R5", 1, 0, 0, 7, -1, -1, 4, 3);
    // R6: step 10 gives 10 only, the match at 20 meets the roll-over
    scen("R6", 1, 0, 0, 10, -1, -1, 2, 3);
    // R9: zero step value gives resets but no steps
    scen("R9", 1, 0, 0, 0, -1, -1, 0, 3);
    // R2 R7: center aligned, set at 4, steps at 9, 14, 19
    scen("R7", 1, 1, 0, 5, 4, -1, 9, 3);
    // R3: hysteretic, step on out1 reset at 12
    scen("R3", 1, 0, 1, 5, -1, 12, 3, 3);
    // R8: set and reset events coincide, reset wins
    scen("R8", 1, 1, 1, 5, 12, 12, 0, 3);
    // R10: disabled, nothing at all
    scen("R10", 0, 0, 0, 5, -1, -1, 0, 0);
    // R1: roll-over reset with out1-reset steps, set events ignored
    scen("R1", 1, 0, 1, 5, 3, 8, 3, 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule